// File: doc/BRIEF.md
# Deferred Write-Back Commit Queue

This block collects the register and program-counter updates that every slot of one wide instruction packet produces while the packet executes. It then applies them to architectural state once the packet ends. Each queued entry records a kind, a target register index, a data value, the address of the instruction that produced it, and a force flag. Alongside the queue, the block can hold one pending imprecise-exception descriptor. The descriptor gives the faulting instruction's address, whether the fault is a floating-point one, and the floating-point status mask.

A `commit_start` pulse begins the drain. Entries leave in enqueue order, one per cycle, and each surviving register write appears on a register-file write port. While an entry is on the port, the current-PC output shows the address of the instruction that issued it. Two filters decide which entries take effect. Only the first surviving branch entry sets the next PC. Entries from the faulting instruction are dropped unless they are forced, or unless the floating-point fault is benign. After the last entry the block loads the final PC, can also update the link register, empties the queue and pulses `commit_done`.

Top module: `pkt_commit_queue`

## Requirements
- R1: After reset the block is idle (`busy`=0), `rf_we`, `commit_done`, `lr_we` and `ovf_err` are 0, and `cur_pc` equals `RESET_PC`.
- R2: During a drain, entries are taken one per cycle in the order they were enqueued. For a register entry (kind code 0, or the unused code 3) that is not suppressed, `rf_we`=1 with that entry's index and value. In each drain cycle, `cur_pc` equals the issuing address of the entry being processed.
- R3: Kind codes 1 (direct branch) and 2 (function branch) are PC writes and never assert `rf_we`. The first unsuppressed PC write in the drain sets the final PC to its value, and every later PC write is skipped.
- R4: If no PC write takes effect, the final PC equals `next_pc` as sampled with `commit_start`. The final PC appears on `cur_pc` from the `commit_done` cycle onward and stays there until the next drain.
- R5: With a pending non-floating-point descriptor, an entry whose issuing address matches the descriptor commits only if its force flag is 1. Entries from other addresses commit normally.
- R6: With a pending floating-point descriptor, a matching entry commits only when the status mask has no bit set above bit 2. Bit 0 is inexact, bit 1 is underflow and bit 2 is overflow. The force flag is then irrelevant.
- R7: A suppressed PC write neither sets the final PC nor blocks a later PC write.
- R8: If `link_set` was pulsed since the last drain, the `commit_done` cycle also has `lr_we`=1 and `lr_data` equal to the sampled `next_pc`. The pending link flag is then cleared, so the next drain does not update the link register.
- R9: `pkt_start` empties the queue and discards the exception descriptor. An enqueue or `exc_set` in the same cycle takes effect after the clearing.
- R10: An enqueue while `DEPTH` entries are held drops the entry and sets `ovf_err`. `ovf_err` stays 1 until reset.
- R11: `commit_done` is a one-cycle pulse. It comes N+1 cycles after the `commit_start` edge for N queued entries, or in the very next cycle for an empty queue. Afterwards the queue is empty.
- R12: While a drain is in progress, and in the cycle of an accepted `commit_start`, the inputs `commit_start`, `pkt_start`, `enq_valid`, `exc_set` and `link_set` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | New packet: empty queue, drop descriptor |
| enq_valid | input | 1 | Enqueue one entry |
| enq_kind | input | 2 | 0 register, 1 direct branch, 2 function branch |
| enq_idx | input | IW | Target register index |
| enq_value | input | DW | Write data or branch target |
| enq_iaddr | input | AW | Address of issuing instruction |
| enq_force | input | 1 | Commit even if the instruction faulted (non-FP) |
| exc_set | input | 1 | Load the imprecise-exception descriptor |
| exc_iaddr | input | AW | Faulting instruction address |
| exc_fp | input | 1 | Descriptor is a floating-point fault |
| exc_mask | input | MW | Floating-point status mask |
| link_set | input | 1 | Mark a pending link-register update |
| next_pc | input | AW | Next-packet PC, sampled with commit_start |
| commit_start | input | 1 | Begin the drain |
| busy | output | 1 | Drain in progress |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | IW | Register-file write index |
| rf_data | output | DW | Register-file write data |
| cur_pc | output | AW | Current PC (issuing address while draining) |
| commit_done | output | 1 | One-cycle end-of-drain pulse |
| lr_we | output | 1 | Link-register write enable |
| lr_data | output | AW | Link-register write data |
| ovf_err | output | 1 | Sticky enqueue-overflow error |

## Verification
The bench builds the block with `DEPTH`=4 and the default widths. The small depth makes the overflow path reachable with five enqueues, and a full queue still drains in a handful of cycles. Address and data stay 32 bits wide, so the bench can tell apart the issuing addresses, the branch targets and the sampled `next_pc`. The 8-bit mask holds both the benign low bits and a harmful higher bit.

// File: rtl/pcq_pkg.sv
// Shared definitions for the packet commit queue.
// Assumes the kind field is two bits wide; code 3 is treated as a register write.
package pcq_pkg;
    typedef enum logic [1:0] {
        WB_REG       = 2'd0,
        WB_PC_DIRECT = 2'd1,
        WB_PC_FUNC   = 2'd2,
        WB_SPARE     = 2'd3
    } wb_kind_e;

    // Low status-mask bits that count as a benign FP fault (inexact, underflow, overflow).
    localparam int BENIGN_BITS = 3;

    // True for the two branch kinds.
    function automatic logic kind_is_pc(input logic [1:0] k);
        return (k == WB_PC_DIRECT) || (k == WB_PC_FUNC);
    endfunction
endpackage

// File: rtl/pcq_store.sv
// Entry storage for the commit queue: an array of packed entries and a fill count.
// Writes land at the fill position; a clear resets the count before any same-cycle write.
// Assumes the reader never indexes past the fill count.
module pcq_store #(
    parameter int DEPTH = 8,
    parameter int EW    = 72,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_data,
    input  logic [PW-1:0] rd_ptr,
    output logic [EW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          ovf_err
);
    logic [EW-1:0] mem [DEPTH];
    logic [CW-1:0] base;
    logic          full;
    logic          wr_ok;

    // Fill level seen by this cycle's write, after any clear.
    always_comb begin
        base  = clear ? '0 : count;
        full  = (base == CW'(DEPTH));
        wr_ok = wr_en && !full;
    end

    // Track the number of held entries.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= base + CW'(wr_ok);
    end

    // Sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf_err <= 1'b0;
        else if (wr_en && full)  ovf_err <= 1'b1;
    end

    // Store an accepted entry at the fill position.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[base[PW-1:0]] <= wr_data;
    end

    // Present the entry at the drain pointer.
    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/pcq_filter.sv
// Per-entry commit decision: exception suppression and first-branch selection.
// Purely combinational; the caller holds the descriptor and the taken flag.
module pcq_filter #(
    parameter int AW = 32,
    parameter int MW = 8
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] iaddr,
    input  logic          force_wr,
    input  logic          exc_valid,
    input  logic [AW-1:0] exc_iaddr,
    input  logic          exc_fp,
    input  logic [MW-1:0] exc_mask,
    input  logic          taken,
    output logic          reg_wr,
    output logic          take_pc
);
    import pcq_pkg::*;

    logic hit;
    logic harmful;
    logic blocked;

    // Suppress entries of the faulting instruction unless forced or the FP fault is benign.
    always_comb begin
        hit     = exc_valid && (iaddr == exc_iaddr);
        harmful = |(exc_mask >> BENIGN_BITS);
        blocked = hit && (exc_fp ? harmful : !force_wr);
        reg_wr  = !blocked && !kind_is_pc(kind);
        take_pc = !blocked && kind_is_pc(kind) && !taken;
    end
endmodule

// File: rtl/pkt_commit_queue.sv
// Deferred write-back commit queue for one instruction packet.
// Collects entries while idle, then drains them one per cycle after commit_start,
// driving the register-file port, the current PC, the final PC and the link update.
// Assumes DW >= AW so that a branch value carries a full target address.
module pkt_commit_queue #(
    parameter int          DEPTH    = 8,
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter int          IW       = 6,
    parameter int          MW       = 8,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_start,
    input  logic          enq_valid,
    input  logic [1:0]    enq_kind,
    input  logic [IW-1:0] enq_idx,
    input  logic [DW-1:0] enq_value,
    input  logic [AW-1:0] enq_iaddr,
    input  logic          enq_force,
    input  logic          exc_set,
    input  logic [AW-1:0] exc_iaddr,
    input  logic          exc_fp,
    input  logic [MW-1:0] exc_mask,
    input  logic          link_set,
    input  logic [AW-1:0] next_pc,
    input  logic          commit_start,
    output logic          busy,
    output logic          rf_we,
    output logic [IW-1:0] rf_idx,
    output logic [DW-1:0] rf_data,
    output logic [AW-1:0] cur_pc,
    output logic          commit_done,
    output logic          lr_we,
    output logic [AW-1:0] lr_data,
    output logic          ovf_err
);
    localparam int EW = 2 + IW + DW + AW + 1;
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          busy_q, taken_q, link_q, done_q, lr_q, exc_v_q, exc_fp_q;
    logic [PW-1:0] rd_ptr;
    logic [AW-1:0] target_q, saved_q, pc_q, exc_ia_q;
    logic [MW-1:0] exc_mask_q;
    logic [CW-1:0] count;
    logic [EW-1:0] wr_data, rd_data;
    logic          accept_cfg, start_ok, clear, wr_en, last, finish;
    logic          reg_wr, take_pc;
    logic [1:0]    e_kind;
    logic [IW-1:0] e_idx;
    logic [DW-1:0] e_value;
    logic [AW-1:0] e_iaddr, final_pc;
    logic          e_force;

    // Control decode: what is accepted this cycle and when the drain ends.
    always_comb begin
        accept_cfg = !busy_q && !commit_start;
        start_ok   = commit_start && !busy_q;
        last       = (CW'(rd_ptr) + CW'(1)) == count;
        finish     = (busy_q && last) || (start_ok && (count == '0));
        clear      = (pkt_start && accept_cfg) || finish;
        wr_en      = enq_valid && accept_cfg;
        wr_data    = {enq_kind, enq_idx, enq_value, enq_iaddr, enq_force};
        {e_kind, e_idx, e_value, e_iaddr, e_force} = rd_data;
    end

    pcq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .wr_data(wr_data),
        .rd_ptr(rd_ptr), .rd_data(rd_data), .count(count), .ovf_err(ovf_err)
    );

    pcq_filter #(.AW(AW), .MW(MW)) u_filter (
        .kind(e_kind), .iaddr(e_iaddr), .force_wr(e_force), .exc_valid(exc_v_q),
        .exc_iaddr(exc_ia_q), .exc_fp(exc_fp_q), .exc_mask(exc_mask_q),
        .taken(taken_q), .reg_wr(reg_wr), .take_pc(take_pc)
    );

    // Final PC: first taken branch, else the sampled next-packet PC.
    always_comb begin
        if (!busy_q)      final_pc = next_pc;
        else if (take_pc) final_pc = AW'(e_value);
        else if (taken_q) final_pc = target_q;
        else              final_pc = saved_q;
    end

    // Drain sequencer: busy flag, pointer, branch capture and saved PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            rd_ptr   <= '0;
            taken_q  <= 1'b0;
            target_q <= '0;
            saved_q  <= '0;
        end else if (start_ok) begin
            busy_q   <= (count != '0);
            rd_ptr   <= '0;
            taken_q  <= 1'b0;
            saved_q  <= next_pc;
        end else if (busy_q) begin
            if (finish) busy_q <= 1'b0;
            else        rd_ptr <= rd_ptr + PW'(1);
            if (take_pc) begin
                taken_q  <= 1'b1;
                target_q <= AW'(e_value);
            end
        end
    end

    // Imprecise-exception descriptor, cleared at packet start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_v_q    <= 1'b0;
            exc_fp_q   <= 1'b0;
            exc_ia_q   <= '0;
            exc_mask_q <= '0;
        end else if (accept_cfg) begin
            if (pkt_start) exc_v_q <= 1'b0;
            if (exc_set) begin
                exc_v_q    <= 1'b1;
                exc_fp_q   <= exc_fp;
                exc_ia_q   <= exc_iaddr;
                exc_mask_q <= exc_mask;
            end
        end
    end

    // Pending link flag, set by a linking branch and consumed by the drain.
    always_ff @(posedge clk) begin
        if (!rst_n)                      link_q <= 1'b0;
        else if (finish)                 link_q <= 1'b0;
        else if (link_set && accept_cfg) link_q <= 1'b1;
    end

    // End-of-drain results: done pulse, link write and architectural PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            lr_q   <= 1'b0;
            pc_q   <= RESET_PC;
        end else begin
            done_q <= finish;
            lr_q   <= finish && link_q;
            if (finish) pc_q <= final_pc;
        end
    end

    assign busy        = busy_q;
    assign rf_we       = busy_q && reg_wr;
    assign rf_idx      = e_idx;
    assign rf_data     = e_value;
    assign cur_pc      = busy_q ? e_iaddr : pc_q;
    assign commit_done = done_q;
    assign lr_we       = lr_q;
    assign lr_data     = saved_q;
endmodule

// File: rtl/pcq_checker.sv
// Protocol checks for pkt_commit_queue, attached with bind.
// Observes ports only; assumes synchronous active-low reset.
module pcq_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rf_we,
    input logic          commit_done,
    input logic          lr_we,
    input logic          ovf_err,
    input logic [AW-1:0] cur_pc
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> !commit_done);
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> !busy && !rf_we);
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
    // R8
    lr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> commit_done);
    // R4
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !commit_done) |-> $stable(cur_pc));
endmodule

bind pkt_commit_queue pcq_checker #(.AW(AW)) u_pcq_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rf_we(rf_we), .commit_done(commit_done),
    .lr_we(lr_we), .ovf_err(ovf_err), .cur_pc(cur_pc)
);

// File: tb/test_pkt_commit_queue.sv
`timescale 1ns/1ps
module test_pkt_commit_queue;
    localparam int DEPTH = 4;

    logic        clk = 0, rst_n = 0;
    logic        pkt_start = 0, enq_valid = 0, enq_force = 0, exc_set = 0, exc_fp = 0;
    logic        link_set = 0, commit_start = 0;
    logic [1:0]  enq_kind = 0;
    logic [5:0]  enq_idx = 0;
    logic [31:0] enq_value = 0, enq_iaddr = 0, exc_iaddr = 0, next_pc = 0;
    logic [7:0]  exc_mask = 0;
    logic        busy, rf_we, commit_done, lr_we, ovf_err;
    logic [5:0]  rf_idx;
    logic [31:0] rf_data, cur_pc, lr_data;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    typedef struct { logic [5:0] idx; logic [31:0] data; logic [31:0] pc; string tag; } wr_t;
    typedef struct { logic [31:0] pc; logic lr; logic [31:0] lrd; string tag; } dn_t;
    wr_t wq[$];
    dn_t dq[$];

    pkt_commit_queue #(.DEPTH(DEPTH)) i_pkt_commit_queue (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .enq_valid(enq_valid),
        .enq_kind(enq_kind), .enq_idx(enq_idx), .enq_value(enq_value),
        .enq_iaddr(enq_iaddr), .enq_force(enq_force), .exc_set(exc_set),
        .exc_iaddr(exc_iaddr), .exc_fp(exc_fp), .exc_mask(exc_mask),
        .link_set(link_set), .next_pc(next_pc), .commit_start(commit_start),
        .busy(busy), .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
        .cur_pc(cur_pc), .commit_done(commit_done), .lr_we(lr_we),
        .lr_data(lr_data), .ovf_err(ovf_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Scoreboard monitor: compares every write and every done pulse.
    always @(negedge clk) begin
        wr_t w;
        dn_t d;
        if (rst_n) begin
            if (rf_we) begin
                if (wq.size() == 0) chk(0, "R2", "unexpected write idx", 32'(rf_idx), 0);
                else begin
                    w = wq.pop_front();
                    chk(rf_idx == w.idx, w.tag, "write idx", 32'(rf_idx), 32'(w.idx));
                    chk(rf_data == w.data, w.tag, "write data", rf_data, w.data);
                    chk(cur_pc == w.pc, w.tag, "issuing pc", cur_pc, w.pc);
                end
            end
            if (commit_done) begin
                if (dq.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
                else begin
                    d = dq.pop_front();
                    chk(cur_pc == d.pc, d.tag, "final pc", cur_pc, d.pc);
                    chk(lr_we == d.lr, d.tag, "lr_we", 32'(lr_we), 32'(d.lr));
                    if (d.lr) chk(lr_data == d.lrd, d.tag, "lr_data", lr_data, d.lrd);
                end
            end
        end
    end

    task automatic ew(input logic [5:0] idx, input logic [31:0] data,
                      input logic [31:0] pc, input string tag);
        wr_t w;
        w.idx = idx; w.data = data; w.pc = pc; w.tag = tag;
        wq.push_back(w);
    endtask

    task automatic ed(input logic [31:0] pc, input logic lr, input logic [31:0] lrd,
                      input string tag);
        dn_t d;
        d.pc = pc; d.lr = lr; d.lrd = lrd; d.tag = tag;
        dq.push_back(d);
    endtask

    task automatic pstart();
        pkt_start = 1; @(negedge clk); pkt_start = 0;
    endtask

    task automatic enq(input logic [1:0] k, input logic [5:0] idx, input logic [31:0] v,
                       input logic [31:0] ia, input logic f);
        enq_valid = 1; enq_kind = k; enq_idx = idx; enq_value = v; enq_iaddr = ia;
        enq_force = f;
        @(negedge clk);
        enq_valid = 0;
    endtask

    task automatic exc(input logic [31:0] ia, input logic fp, input logic [7:0] m);
        exc_set = 1; exc_iaddr = ia; exc_fp = fp; exc_mask = m;
        @(negedge clk);
        exc_set = 0;
    endtask

    task automatic link();
        link_set = 1; @(negedge clk); link_set = 0;
    endtask

    // Drain and check latency (R11) and that every expected item appeared.
    task automatic commit(input logic [31:0] npc, input int n, input string tag);
        int cyc;
        next_pc = npc; commit_start = 1;
        @(negedge clk);
        commit_start = 0;
        cyc = 1;
        while (!commit_done && cyc < 100) begin @(negedge clk); cyc++; end
        chk(cyc == n + 1, "R11", "done latency", 32'(cyc), 32'(n + 1));
        @(negedge clk);
        chk(wq.size() == 0, tag, "missing writes", 32'(wq.size()), 0);
        chk(dq.size() == 0, tag, "missing done", 32'(dq.size()), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy", 32'(busy), 0);
        chk(rf_we == 0 && commit_done == 0 && lr_we == 0, "R1", "outputs idle",
            32'({rf_we, commit_done, lr_we}), 0);
        chk(ovf_err == 0, "R1", "ovf_err", 32'(ovf_err), 0);
        chk(cur_pc == 0, "R1", "cur_pc", cur_pc, 0);

        // R2 ordered register writes, R4 fall-through PC
        pstart();
        enq(2'd0, 6'd3, 32'hA3, 32'h1000, 0); ew(6'd3, 32'hA3, 32'h1000, "R2");
        enq(2'd0, 6'd7, 32'hB7, 32'h1004, 0); ew(6'd7, 32'hB7, 32'h1004, "R2");
        enq(2'd3, 6'd1, 32'hC1, 32'h1008, 0); ew(6'd1, 32'hC1, 32'h1008, "R2");
        ed(32'h1010, 0, 0, "R4");
        commit(32'h1010, 3, "R2");
        chk(cur_pc == 32'h1010, "R4", "pc held after drain", cur_pc, 32'h1010);

        // R3 first branch wins, later branch skipped
        pstart();
        enq(2'd0, 6'd2, 32'h22, 32'h2000, 0); ew(6'd2, 32'h22, 32'h2000, "R3");
        enq(2'd1, 6'd0, 32'h200, 32'h2004, 0);
        enq(2'd0, 6'd4, 32'h44, 32'h2008, 0); ew(6'd4, 32'h44, 32'h2008, "R3");
        enq(2'd2, 6'd0, 32'h300, 32'h200C, 0);
        ed(32'h200, 0, 0, "R3");
        commit(32'h2010, 4, "R3");

        // R5 non-FP fault filter, R7 suppressed branch does not count
        pstart();
        exc(32'h3000, 0, 8'h00);
        enq(2'd0, 6'd5, 32'h55, 32'h3000, 0);
        enq(2'd0, 6'd6, 32'h66, 32'h3000, 1); ew(6'd6, 32'h66, 32'h3000, "R5");
        enq(2'd1, 6'd0, 32'h999, 32'h3000, 0);
        enq(2'd2, 6'd0, 32'h400, 32'h3004, 0);
        ed(32'h400, 0, 0, "R7");
        commit(32'h3010, 4, "R5");

        // R6 benign FP fault commits
        pstart();
        exc(32'h4000, 1, 8'h05);
        enq(2'd0, 6'd8, 32'h88, 32'h4000, 0); ew(6'd8, 32'h88, 32'h4000, "R6");
        ed(32'h4010, 0, 0, "R6");
        commit(32'h4010, 1, "R6");

        // R6 harmful FP fault blocks even forced entries
        pstart();
        exc(32'h4100, 1, 8'h09);
        enq(2'd0, 6'd9, 32'h99, 32'h4100, 1);
        enq(2'd0, 6'd10, 32'hAA, 32'h4104, 0); ew(6'd10, 32'hAA, 32'h4104, "R6");
        ed(32'h4110, 0, 0, "R6");
        commit(32'h4110, 2, "R6");

        // R9 packet start empties queue
        enq(2'd0, 6'd11, 32'hBB, 32'h5000, 0);
        pstart();
        ed(32'h5010, 0, 0, "R9");
        commit(32'h5010, 0, "R9");

        // R9 packet start drops descriptor
        exc(32'h5100, 0, 8'h00);
        pstart();
        enq(2'd0, 6'd12, 32'hCC, 32'h5100, 0); ew(6'd12, 32'hCC, 32'h5100, "R9");
        ed(32'h5110, 0, 0, "R9");
        commit(32'h5110, 1, "R9");

        // R8 link update then cleared
        pstart();
        link();
        enq(2'd2, 6'd0, 32'h600, 32'h6000, 0);
        ed(32'h600, 1, 32'h6004, "R8");
        commit(32'h6004, 1, "R8");
        ed(32'h6100, 0, 0, "R8");
        commit(32'h6100, 0, "R8");

        // R12 inputs ignored while draining
        pstart();
        enq(2'd0, 6'd13, 32'hD1, 32'h7000, 0); ew(6'd13, 32'hD1, 32'h7000, "R12");
        enq(2'd0, 6'd14, 32'hD2, 32'h7004, 0); ew(6'd14, 32'hD2, 32'h7004, "R12");
        ed(32'h7010, 0, 0, "R12");
        next_pc = 32'h7010; commit_start = 1;
        @(negedge clk);
        enq_valid = 1; enq_kind = 0; enq_idx = 6'd15; enq_value = 32'hEE;
        enq_iaddr = 32'h7008; enq_force = 0;
        @(negedge clk);
        commit_start = 0; enq_valid = 0;
        while (!commit_done) @(negedge clk);
        @(negedge clk);
        chk(wq.size() == 0 && dq.size() == 0, "R12", "items left", 32'(wq.size()), 0);
        ed(32'h7100, 0, 0, "R12");
        commit(32'h7100, 0, "R12");

        // R10 overflow drops entry, sticky flag
        pstart();
        for (int i = 0; i < DEPTH; i++) begin
            enq(2'd0, 6'(20 + i), 32'(i + 32'h100), 32'h8000 + 32'(4 * i), 0);
            ew(6'(20 + i), 32'(i + 32'h100), 32'h8000 + 32'(4 * i), "R10");
        end
        chk(ovf_err == 0, "R10", "ovf before overflow", 32'(ovf_err), 0);
        enq(2'd0, 6'd30, 32'hFF, 32'h8100, 0);
        chk(ovf_err == 1, "R10", "ovf after overflow", 32'(ovf_err), 1);
        ed(32'h8200, 0, 0, "R10");
        commit(32'h8200, DEPTH, "R10");
        pstart();
        chk(ovf_err == 1, "R10", "ovf sticky", 32'(ovf_err), 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule